// File: doc/BRIEF.md
# SPI Transmit Zero-Fill Controller

This block sits beside the transmit and receive byte FIFOs of a SPI master. Software programs a byte count, and the controller pushes 32-bit words of zeros into the transmit FIFO until that count is used up. Software therefore never writes filler words just to clock read data in from a slave. Pushes are throttled so that the bytes held in both FIFOs never reach the receive FIFO's almost-full margin. This keeps the receive side from overflowing while the shifter turns every transmitted byte into a received byte.

The controller also decides when the transmit FIFO may be drained to the shift engine. In automatic mode, draining is requested whenever the FIFO holds data. In manual-start mode, software arms a sticky start flag. The flag stays set until the FIFO is empty and the byte count has reached zero.

The controller re-evaluates filling after every register write and every time the transmit FIFO runs empty. It signals the end of each evaluation with a one-cycle pulse, which interrupt logic uses to re-sample FIFO levels.

Top module: `spi_zpump_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, `zpush` and `eval_done` are low. The byte count, the manual-start enable, the push-wait bit and the start flag are all cleared.
- R2: While the byte count is zero, no word is pushed.
- R3: While the push-wait bit (bit 0 of the command register at offset 0x04) is 1 and `tx_level` is nonzero, no word is pushed.
- R4: A word is pushed only in a cycle where `rx_level + tx_level < THR - 3`, counting bytes. At most one word is pushed per cycle.
- R5: Each push is a single-cycle `zpush` with `zdata` equal to 32'h0. This stands for four zero bytes.
- R6: Each push first clears the two low bits of the byte count and then subtracts 4, saturating at 0. A count of n > 0 therefore yields max(1, floor(n/4)) words. A write to the count register (offset 0xC4) replaces the count.
- R7: A config write (offset 0x00) with the start bit (bit 1) set arms the start flag only if manual-start enable (bit 0) was already 1 before that write. The start bit is never stored.
- R8: `flush_req` is high exactly when the start flag is set, or when `tx_level` is nonzero and manual-start enable is 0.
- R9: The start flag clears in any cycle where `tx_level` is zero and the byte count is zero, unless that cycle arms it again.
- R10: An evaluation begins the cycle after any register write, or after `tx_level` goes from nonzero to zero. Pushes happen only during an evaluation, and only while the block is requesting a flush. The evaluation ends with a one-cycle `eval_done` in the first evaluating cycle that does not push.
- R11: Writes to addresses other than 0x00, 0x04 and 0xC4 change no register, but they still start an evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte offset |
| wr_data | input | DW | Write data |
| tx_level | input | CW | Transmit FIFO occupancy in bytes |
| rx_level | input | CW | Receive FIFO occupancy in bytes |
| zpush | output | 1 | Push one zero word into the transmit FIFO |
| zdata | output | DW | Word to push (always zero) |
| flush_req | output | 1 | Request the shifter to drain the transmit FIFO |
| eval_done | output | 1 | Pulse at the end of each fill evaluation |

## Verification
A corrupted byte count appears at `zpush` as too many or too few words. The discrepancy becomes visible within one cycle of the push that would otherwise have been the last one. A stuck or lost start flag shows up on `flush_req` in the very cycle that follows the faulty update. A wrong evaluation latch shows as pushes that stop early, or as a missing or extra `eval_done` pulse, one cycle after the triggering write or drain. The bench's behavioural model compares all three outputs every cycle, so any of these faults is caught at its first visible cycle.

// File: rtl/spi_zpump_pkg.sv
package spi_zpump_pkg;
  localparam int AW = 8;
  localparam logic [AW-1:0] ADR_CFG  = 8'h00;
  localparam logic [AW-1:0] ADR_CMD  = 8'h04;
  localparam logic [AW-1:0] ADR_SIZE = 8'hC4;
  localparam int CFG_MEN_BIT  = 0;
  localparam int CFG_GO_BIT   = 1;
  localparam int CMD_WAIT_BIT = 0;
  localparam int WORD_BYTES   = 4;
endpackage

// File: rtl/zpump_regs.sv
module zpump_regs
  import spi_zpump_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          man_en,
  output logic          push_wait,
  output logic          go_ok,
  output logic          size_wr
);
  logic cfg_hit, cmd_hit;
  logic men_d, wait_d;

  assign cfg_hit = wr_en && (wr_addr == ADR_CFG);
  assign cmd_hit = wr_en && (wr_addr == ADR_CMD);
  assign size_wr = wr_en && (wr_addr == ADR_SIZE);
  // R7: the start bit only arms the flag if enable was set before this write
  assign go_ok   = cfg_hit && wr_data[CFG_GO_BIT] && man_en;

  always_comb begin
    men_d  = man_en;
    wait_d = push_wait;
    if (cfg_hit) men_d  = wr_data[CFG_MEN_BIT];
    if (cmd_hit) wait_d = wr_data[CMD_WAIT_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      man_en    <= 1'b0;
      push_wait <= 1'b0;
    end else begin
      man_en    <= men_d;
      push_wait <= wait_d;
    end
  end
endmodule

// File: rtl/zpump_count.sv
module zpump_count
  import spi_zpump_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          size_wr,
  input  logic [DW-1:0] size_din,
  input  logic          step,
  output logic [DW-1:0] size_q,
  output logic          size_nz
);
  localparam int LOW = $clog2(WORD_BYTES);
  logic [DW-1:0] floored, size_d;
  logic          has_word;

  assign floored  = {size_q[DW-1:LOW], {LOW{1'b0}}};
  assign has_word = |size_q[DW-1:LOW];
  assign size_nz  = |size_q;

  // R6: floor to a word multiple, then take one word off, saturating at 0
  always_comb begin
    size_d = size_q;
    if (size_wr)   size_d = size_din;
    else if (step) size_d = has_word ? (floored - DW'(WORD_BYTES)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) size_q <= '0;
    else        size_q <= size_d;
  end
endmodule

// File: rtl/zpump_sched.sv
module zpump_sched #(
  parameter int CW  = 7,
  parameter int THR = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          go_ok,
  input  logic          man_en,
  input  logic          push_wait,
  input  logic          size_nz,
  input  logic [CW-1:0] tx_level,
  input  logic [CW-1:0] rx_level,
  output logic          fill,
  output logic          flush_req,
  output logic          eval_done
);
  localparam int LIMIT = THR - 3;
  localparam int SW    = CW + 1;

  logic [SW-1:0] occ;
  logic tx_nz, txnz_q, eval_q, eval_d, flag_q, flag_d, active, room, drained;

  assign tx_nz   = |tx_level;
  assign occ     = {1'b0, rx_level} + {1'b0, tx_level};
  assign room    = occ < SW'(LIMIT);
  assign drained = txnz_q && !tx_nz;
  assign active  = flag_q || (tx_nz && !man_en);

  assign fill      = eval_q && active && size_nz && !(tx_nz && push_wait) && room;
  assign flush_req = active;
  assign eval_done = eval_q && !fill;

  always_comb begin
    eval_d = wr_en || drained || (eval_q && fill);
    flag_d = flag_q;
    if (go_ok)                   flag_d = 1'b1;
    else if (!tx_nz && !size_nz) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eval_q <= 1'b0;
      flag_q <= 1'b0;
      txnz_q <= 1'b0;
    end else begin
      eval_q <= eval_d;
      flag_q <= flag_d;
      txnz_q <= tx_nz;
    end
  end
endmodule

// File: rtl/spi_zpump_ctrl.sv
module spi_zpump_ctrl
  import spi_zpump_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int THR   = DEPTH,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [CW-1:0] tx_level,
  input  logic [CW-1:0] rx_level,
  output logic          zpush,
  output logic [DW-1:0] zdata,
  output logic          flush_req,
  output logic          eval_done
);
  logic          man_en_q, push_wait_q, go_ok, size_wr, size_nz;
  logic [DW-1:0] size_q;

  zpump_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .man_en(man_en_q), .push_wait(push_wait_q), .go_ok(go_ok), .size_wr(size_wr)
  );

  zpump_count #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .size_wr(size_wr), .size_din(wr_data),
    .step(zpush), .size_q(size_q), .size_nz(size_nz)
  );

  zpump_sched #(.CW(CW), .THR(THR)) u_sched (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .go_ok(go_ok), .man_en(man_en_q),
    .push_wait(push_wait_q), .size_nz(size_nz), .tx_level(tx_level),
    .rx_level(rx_level), .fill(zpush), .flush_req(flush_req), .eval_done(eval_done)
  );

  // R5: filler is all-zero; byte order is irrelevant
  assign zdata = '0;
endmodule

// File: rtl/spi_zpump_chk.sv
module spi_zpump_chk #(
  parameter int DW    = 32,
  parameter int CW    = 7,
  parameter int LIMIT = 61
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [CW-1:0] tx_level,
  input logic [CW-1:0] rx_level,
  input logic          zpush,
  input logic          flush_req,
  input logic          eval_done,
  input logic          man_en_q,
  input logic          push_wait_q,
  input logic [DW-1:0] size_q
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!zpush && !eval_done && size_q == '0));

  p_zero_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (size_q == '0) |-> !zpush);

  p_wait_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_wait_q && tx_level != '0) |-> !zpush);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    zpush |-> (({1'b0, rx_level} + {1'b0, tx_level}) < (CW+1)'(LIMIT)));

  p_count_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (zpush && !wr_en) |=> (size_q < $past(size_q)));

  p_auto_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_en_q && tx_level != '0) |-> flush_req);
endmodule

bind spi_zpump_ctrl spi_zpump_chk #(.DW(DW), .CW(CW), .LIMIT(THR - 3)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tx_level(tx_level), .rx_level(rx_level),
  .zpush(zpush), .flush_req(flush_req), .eval_done(eval_done),
  .man_en_q(man_en_q), .push_wait_q(push_wait_q), .size_q(size_q)
);

// File: tb/sim_spi_zpump_ctrl.sv
`timescale 1ns/1ps
module sim_spi_zpump_ctrl;
  localparam int DW = 32, DEPTH = 64, THR = 64, CW = 7;
  localparam int LIMIT = THR - 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, wr_en, zpush, flush_req, eval_done;
  logic [7:0] wr_addr;
  logic [DW-1:0] wr_data, zdata;
  logic [CW-1:0] tx_level, rx_level;

  spi_zpump_ctrl #(.DW(DW), .DEPTH(DEPTH), .THR(THR)) u0 (.*);

  int n_chk = 0, n_err = 0;
  int tx = 0, rx = 0, srate = 0, rdrate = 0, pushes = 0;
  bit m_en, m_wait, m_flag, m_pend, m_txnz;
  longint m_size;

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive inputs, compare with the reference, advance the model
  task automatic cyc(bit we, logic [7:0] a, logic [31:0] d, int add);
    bit e_act, e_push, e_evp, n_flag;
    longint fl;
    int sh, rd;
    wr_en = we; wr_addr = a; wr_data = d;
    tx_level = CW'(tx); rx_level = CW'(rx);
    #1;
    e_act  = m_flag || (tx != 0 && !m_en);
    e_push = m_pend && e_act && m_size != 0 && !(tx != 0 && m_wait) && (rx + tx < LIMIT);
    e_evp  = m_pend && !e_push;
    chk("R4 zpush", zpush, e_push);
    chk("R8 flush_req", flush_req, e_act);
    chk("R10 eval_done", eval_done, e_evp);
    if (zpush) begin
      pushes++;
      chk("R5 zdata", zdata, 0);
    end
    chk("R4 fifo bound", (tx + rx <= DEPTH), 1);
    n_flag = m_flag;
    if (we && a == 8'h00 && d[1] && m_en) n_flag = 1;
    else if (tx == 0 && m_size == 0)      n_flag = 0;
    m_pend = we || (m_txnz && tx == 0) || (m_pend && e_push);
    m_txnz = (tx != 0);
    m_flag = n_flag;
    if (we && a == 8'hC4) m_size = d;
    else if (e_push) begin
      fl = (m_size / 4) * 4;
      m_size = (fl >= 4) ? fl - 4 : 0;
    end
    if (we && a == 8'h00) m_en = d[0];
    if (we && a == 8'h04) m_wait = d[0];
    sh = e_act ? ((tx < srate) ? tx : srate) : 0;
    rd = (rx < rdrate) ? rx : rdrate;
    @(posedge clk);
    @(negedge clk);
    tx = tx - sh + (e_push ? 4 : 0) + add;
    rx = rx + sh - rd;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 0);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    cyc(1, a, d, 0);
  endtask

  // software writes one data word into the TX FIFO (unmapped address here)
  task automatic sw_word();
    cyc(1, 8'h1C, 32'hA5A5A5A5, 4);
  endtask

  int base;

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0; tx_level = 0; rx_level = 0;
    m_en = 0; m_wait = 0; m_flag = 0; m_pend = 0; m_txnz = 0; m_size = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset zpush", zpush, 0);
    chk("R1 reset eval_done", eval_done, 0);
    chk("R1 reset flush_req", flush_req, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R2: zero count, automatic mode: flush but no pushes
    srate = 1; rdrate = 4; base = pushes;
    sw_word(); idle(20);
    chk("R2 no push at zero count", pushes - base, 0);

    // R11: unmapped write leaves count at zero (still no push)
    wr(8'h08, 32'hFFFF_FFFF); sw_word(); idle(20);
    chk("R11 unmapped write ignored", pushes - base, 0);

    // R6/R10: automatic mode, 20 bytes -> 5 words
    base = pushes;
    wr(8'hC4, 20); idle(2);
    chk("R10 no push while idle FIFO", pushes - base, 0);
    sw_word(); idle(40);
    chk("R6 count 20 gives 5 words", pushes - base, 5);

    // R6 rounding cases
    base = pushes; wr(8'hC4, 7); sw_word(); idle(30);
    chk("R6 count 7 gives 1 word", pushes - base, 1);
    base = pushes; wr(8'hC4, 3); sw_word(); idle(30);
    chk("R6 count 3 gives 1 word", pushes - base, 1);
    base = pushes; wr(8'hC4, 9); sw_word(); idle(30);
    chk("R6 count 9 gives 2 words", pushes - base, 2);

    // R7: start bit ignored unless enable already set
    base = pushes;
    wr(8'hC4, 8);
    wr(8'h00, 32'h2); idle(2);
    chk("R7 go without enable", flush_req, 0);
    wr(8'h00, 32'h3); idle(2);
    chk("R7 go with enable in same write", flush_req, 0);
    chk("R7 no push before arm", pushes - base, 0);
    wr(8'h00, 32'h3); idle(40);
    chk("R7 armed start pushes 2 words", pushes - base, 2);
    chk("R9 flag cleared after done", flush_req, 0);

    // R3: push-wait in manual mode
    base = pushes;
    wr(8'h04, 1); wr(8'hC4, 8); sw_word();
    chk("R8 manual mode holds data", flush_req, 0);
    wr(8'h00, 32'h3); idle(2);
    chk("R3 wait blocks while FIFO busy", pushes - base, 0);
    idle(40);
    chk("R3 one word per drain, 2 total", pushes - base, 2);
    chk("R9 flag clear after wait run", flush_req, 0);

    // R4: occupancy throttle, shifter stalled
    wr(8'h04, 0); srate = 0; rdrate = 0; base = pushes;
    wr(8'hC4, 400); wr(8'h00, 32'h3); idle(30);
    chk("R4 fill stops at margin", pushes - base, 16);
    srate = 2; idle(40);
    chk("R4 no push while RX full", pushes - base, 16);
    rdrate = 4; idle(20);
    wr(8'h1C, 0); idle(600);
    chk("R6 count 400 gives 100 words", pushes - base, 100);
    idle(40);
    chk("R9 flag cleared at end", flush_req, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule